// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Front End

This block connects a small byte-wide register array to a processor bus that shares one set of lines between address and data. A strap input picks one of two timing styles for the same pins. With the strap high, the block uses an address strobe, a data strobe and a read/write level. With the strap low, the data-strobe pin becomes an active-low read pulse, and the read/write pin becomes an active-low write pulse. In both styles the address comes off the shared bus when the address strobe falls.

Every data access needs three things: an active-low chip select, an inactive power-fail input and a high bus reset input. All three must hold for the whole data pulse. A pulse that starts without them, or that loses them part way through, has no effect. Address capture does not depend on the qualifiers. The block samples all bus pins on its own clock. It drives the bus only during a qualified read, and it stores write data when the write pulse ends. A 128-byte array sits behind the front end so the access paths can be exercised.

Top module: `dualBusFront`

## Requirements
- R1: With the mode strap high, a qualified pulse on the data strobe with the read/write pin high is a read. During the read, busOe is high and adBusOut carries the array byte at the latched address.
- R2: With the mode strap high, a qualified data-strobe pulse with the read/write pin low is a write. When the data strobe falls, the byte held on the bus during the pulse is stored at the latched address. writeEn is high for exactly one clock cycle at that point.
- R3: With the mode strap low, a low dataStb is a read pulse and a low rdWr is a write pulse. The write is stored when rdWr returns high.
- R4: On every falling edge of addrStb, latchedAddr takes the low ADDR_W bits of adBusIn. Bits above ADDR_W are ignored. This happens whatever the state of chipSel_n, powerFail or busReset_n.
- R5: A data pulse that begins while chipSel_n is high performs no read and no write. busOe stays low and the array is unchanged.
- R6: If chipSel_n goes high during a data pulse, the access is abandoned. busOe drops before the pulse ends, and an abandoned write is not stored.
- R7: While powerFail is high, no read or write takes place.
- R8: While busReset_n is low, no read or write takes place. Driving it low does not alter the array contents.
- R9: busOe is low whenever no qualified read is in progress. adBusOut is all zeros whenever busOe is low.
- R10: The system reset rst_n clears every array byte and latchedAddr to zero, and holds busOe, readEn and writeEn low.
- R11: readEn is high for exactly one clock cycle at the start of each qualified read, in the cycle before busOe rises.
- R12: With the mode strap low, if dataStb and rdWr are both low, the pulse is treated as a write only. No read takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock that samples all bus pins |
| rst_n | input | 1 | Active-low system reset; clears the array and the control state |
| busReset_n | input | 1 | Active-low bus reset; blocks all accesses while low |
| modeStrap | input | 1 | 1 = address/data strobe with read/write level; 0 = separate active-low read and write pulses |
| chipSel_n | input | 1 | Active-low chip select |
| addrStb | input | 1 | Address strobe; the address is captured on its falling edge |
| dataStb | input | 1 | Data strobe (strap high) or active-low read pulse (strap low) |
| rdWr | input | 1 | Read/write level (strap high) or active-low write pulse (strap low) |
| powerFail | input | 1 | High while supply power is failing; blocks accesses |
| adBusIn | input | DATA_W | Shared address/data bus, input side |
| adBusOut | output | DATA_W | Shared bus, output side; zero when not driven |
| busOe | output | 1 | Bus output enable, high only during a qualified read |
| readEn | output | 1 | One-cycle pulse at the start of a qualified read |
| writeEn | output | 1 | One-cycle pulse when a write is stored |
| latchedAddr | output | ADDR_W | Most recently captured address |

## Verification
The bench uses the default build: ADDR_W = 7 and DATA_W = 8. With these values the bus is one bit wider than the address. An address byte with its top bit set therefore shows whether upper bus bits are dropped when the address is latched. The 128-entry array is small enough to keep a full model, so both the highest and lowest locations are reached and the contents can be compared after bus reset and system reset. Both strap settings run against the same array. This lets data written in one timing style be read back in the other.

// File: rtl/busFrontPkg.sv
package busFrontPkg;

  // Access state of the bus front end.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_BLOCK = 2'd3
  } busState_e;

  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic latchAddr;  // take the sampled bus as the new address
    logic holdData;   // keep the sampled bus as pending write data
    logic commit;     // store the pending write data in the array
    logic readOn;     // drive the selected array byte onto the bus
  } busStrobe_t;

endpackage

// File: rtl/busFrontCtrl.sv
module busFrontCtrl
  import busFrontPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busReset_n,
  input  logic       modeStrap,
  input  logic       chipSel_n,
  input  logic       addrStb,
  input  logic       dataStb,
  input  logic       rdWr,
  input  logic       powerFail,
  output busStrobe_t strobes,
  output logic       readEn
);

  // Pin samples, one register each.
  logic sMode, sCs_n, sAs, sAsPrev, sDs, sRw, sPf, sBrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sMode   <= 1'b1;
      sCs_n   <= 1'b1;
      sAs     <= 1'b0;
      sAsPrev <= 1'b0;
      sDs     <= 1'b0;
      sRw     <= 1'b1;
      sPf     <= 1'b0;
      sBrst   <= 1'b0;
    end else begin
      sMode   <= modeStrap;
      sCs_n   <= chipSel_n;
      sAs     <= addrStb;
      sAsPrev <= sAs;
      sDs     <= dataStb;
      sRw     <= rdWr;
      sPf     <= powerFail;
      sBrst   <= busReset_n;
    end
  end

  // An access is allowed only with chip select on, power good and bus reset off.
  logic accessOk;
  assign accessOk = !sCs_n && !sPf && sBrst;

  // Phase decoding for the two timing styles.
  logic readPhase, writePhase;
  always_comb begin
    if (sMode) begin
      readPhase  = sDs && sRw;
      writePhase = sDs && !sRw;
    end else begin
      writePhase = !sRw;
      readPhase  = !sDs && sRw;   // the write pulse wins if both are low
    end
  end

  busState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (readPhase || writePhase) begin
          if (!accessOk)       stateNext = ST_BLOCK;
          else if (writePhase) stateNext = ST_WRITE;
          else                 stateNext = ST_READ;
        end
      end
      ST_READ: begin
        if (!accessOk)      stateNext = ST_BLOCK;
        else if (!readPhase) stateNext = ST_IDLE;
      end
      ST_WRITE: begin
        if (!accessOk)       stateNext = ST_BLOCK;
        else if (!writePhase) stateNext = ST_IDLE;
      end
      ST_BLOCK: begin
        if (!readPhase && !writePhase) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobes.latchAddr = sAsPrev && !sAs;
    strobes.holdData  = (state == ST_WRITE) && writePhase && accessOk;
    strobes.commit    = (state == ST_WRITE) && !writePhase && accessOk;
    strobes.readOn    = (state == ST_READ);
  end

  assign readEn = (state == ST_IDLE) && accessOk && readPhase && !writePhase;

endmodule

// File: rtl/busFrontData.sv
module busFrontData
  import busFrontPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] adBusIn,
  input  busStrobe_t        strobes,
  output logic [ADDR_W-1:0] latchedAddr,
  output logic [DATA_W-1:0] adBusOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sBus;
  logic [DATA_W-1:0] wrHold;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] rows [DEPTH];

  // The bus is sampled in the same stage as the strobe pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sBus <= '0;
    else        sBus <= adBusIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 addrQ <= '0;
    else if (strobes.latchAddr) addrQ <= sBus[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wrHold <= '0;
    else if (strobes.holdData) wrHold <= sBus;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rows[i] <= '0;
    end else if (strobes.commit) begin
      rows[addrQ] <= wrHold;
    end
  end

  assign latchedAddr = addrQ;
  assign adBusOut    = strobes.readOn ? rows[addrQ] : '0;

endmodule

// File: rtl/dualBusFront.sv
module dualBusFront
  import busFrontPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busReset_n,
  input  logic              modeStrap,
  input  logic              chipSel_n,
  input  logic              addrStb,
  input  logic              dataStb,
  input  logic              rdWr,
  input  logic              powerFail,
  input  logic [DATA_W-1:0] adBusIn,
  output logic [DATA_W-1:0] adBusOut,
  output logic              busOe,
  output logic              readEn,
  output logic              writeEn,
  output logic [ADDR_W-1:0] latchedAddr
);

  busStrobe_t strobes;

  busFrontCtrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .busReset_n (busReset_n),
    .modeStrap  (modeStrap),
    .chipSel_n  (chipSel_n),
    .addrStb    (addrStb),
    .dataStb    (dataStb),
    .rdWr       (rdWr),
    .powerFail  (powerFail),
    .strobes    (strobes),
    .readEn     (readEn)
  );

  busFrontData #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk         (clk),
    .rst_n       (rst_n),
    .adBusIn     (adBusIn),
    .strobes     (strobes),
    .latchedAddr (latchedAddr),
    .adBusOut    (adBusOut)
  );

  assign busOe   = strobes.readOn;
  assign writeEn = strobes.commit;

endmodule

// File: rtl/busFrontChk.sv
module busFrontChk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busReset_n,
  input logic              chipSel_n,
  input logic              powerFail,
  input logic              addrStb,
  input logic              busOe,
  input logic              readEn,
  input logic              writeEn,
  input logic [ADDR_W-1:0] latchedAddr
);

  AST_WREN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    writeEn |=> !writeEn);  // R2

  AST_RDEN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    readEn |=> !readEn);  // R11

  AST_RDEN_OPENS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    readEn |=> busOe);  // R11

  AST_WRITE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    writeEn |-> $past(!chipSel_n && !powerFail && busReset_n));  // R5

  AST_READ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    readEn |-> $past(!chipSel_n && !powerFail && busReset_n));  // R7

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busOe |-> !writeEn);  // R9

  AST_ADDR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latchedAddr) |-> ($past(addrStb, 3) && !$past(addrStb, 2)));  // R4

endmodule

bind dualBusFront busFrontChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busReset_n  (busReset_n),
  .chipSel_n   (chipSel_n),
  .powerFail   (powerFail),
  .addrStb     (addrStb),
  .busOe       (busOe),
  .readEn      (readEn),
  .writeEn     (writeEn),
  .latchedAddr (latchedAddr)
);

// File: tb/test_dualBusFront.sv
module test_dualBusFront;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n, busReset_n, modeStrap, chipSel_n, addrStb, dataStb, rdWr, powerFail;
  logic [DATA_W-1:0] adBusIn, adBusOut;
  logic busOe, readEn, writeEn;
  logic [ADDR_W-1:0] latchedAddr;

  always #10 clk = ~clk;  // 50 MHz

  dualBusFront #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dualBusFront (
    .clk(clk), .rst_n(rst_n), .busReset_n(busReset_n), .modeStrap(modeStrap),
    .chipSel_n(chipSel_n), .addrStb(addrStb), .dataStb(dataStb), .rdWr(rdWr),
    .powerFail(powerFail), .adBusIn(adBusIn), .adBusOut(adBusOut), .busOe(busOe),
    .readEn(readEn), .writeEn(writeEn), .latchedAddr(latchedAddr)
  );

  int checks = 0;
  int errors = 0;
  int wrSeen = 0;
  int rdSeen = 0;
  bit oePrev = 1'b0;
  bit done   = 1'b0;
  string curReq = "R1";
  logic [DATA_W-1:0] model [DEPTH];
  logic [DATA_W-1:0] expQ [$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: scoreboard for read data and pulse counters.
  always @(negedge clk) begin
    if (rst_n) begin
      if (writeEn) wrSeen++;
      if (readEn)  rdSeen++;
      if (busOe && !oePrev) begin
        if (expQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL %s unexpected bus drive: actual data %0h expected none", curReq, adBusOut);
        end else begin
          check(curReq, "read data", 32'(adBusOut), 32'(expQ.pop_front()));
        end
      end
      oePrev = busOe;
    end
  end

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one multiplexed bus cycle in the current timing style.
  task automatic busOp(input bit wr, input bit both, input logic [7:0] a,
                       input logic [7:0] d, input bit hit, input bit abortMid);
    int wrBefore;
    int rdBefore;
    bit expectWrite;
    bit expectRead;
    wrBefore    = wrSeen;
    rdBefore    = rdSeen;
    expectWrite = (wr || both) && hit && !abortMid;
    expectRead  = !wr && !both && hit;
    @(negedge clk);
    adBusIn = a;
    addrStb = 1'b1;
    waitCycles(2);
    addrStb = 1'b0;
    waitCycles(3);
    check("R4", "latched address", 32'(latchedAddr), 32'(a[ADDR_W-1:0]));
    adBusIn = (wr || both) ? d : 8'h00;
    if (expectRead) expQ.push_back(model[a[ADDR_W-1:0]]);
    if (modeStrap) begin
      rdWr = !wr;
      waitCycles(1);
      dataStb = 1'b1;
    end else if (both) begin
      dataStb = 1'b0;
      rdWr    = 1'b0;
    end else if (wr) begin
      rdWr = 1'b0;
    end else begin
      dataStb = 1'b0;
    end
    if (abortMid) begin
      waitCycles(3);
      chipSel_n = 1'b1;
      waitCycles(3);
      check("R6", "bus enable after abort", 32'(busOe), 32'd0);
    end else begin
      waitCycles(5);
      if (both) check("R12", "no read when both pulses low", 32'(busOe), 32'd0);
    end
    if (modeStrap) begin
      dataStb = 1'b0;
      waitCycles(1);
      rdWr = 1'b1;
    end else begin
      dataStb = 1'b1;
      rdWr    = 1'b1;
    end
    waitCycles(4);
    if (abortMid) chipSel_n = 1'b0;
    if (expectWrite) model[a[ADDR_W-1:0]] = d;
    check(curReq, "write pulses", 32'(wrSeen - wrBefore), expectWrite ? 32'd1 : 32'd0);
    check("R11", "read start pulses", 32'(rdSeen - rdBefore),
          (!wr && !both && hit) ? 32'd1 : 32'd0);
    check(curReq, "pending reads", 32'(expQ.size()), 32'd0);
    check("R9", "idle bus enable", 32'(busOe), 32'd0);
    check("R9", "idle bus data", 32'(adBusOut), 32'd0);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rst_n = 1'b0; busReset_n = 1'b1; modeStrap = 1'b1; chipSel_n = 1'b1;
    addrStb = 1'b0; dataStb = 1'b0; rdWr = 1'b1; powerFail = 1'b0; adBusIn = '0;
    waitCycles(5);
    check("R10", "busOe in reset", 32'(busOe), 32'd0);
    check("R10", "writeEn in reset", 32'(writeEn), 32'd0);
    check("R10", "readEn in reset", 32'(readEn), 32'd0);
    check("R10", "latchedAddr in reset", 32'(latchedAddr), 32'd0);
    rst_n = 1'b1;
    waitCycles(3);
    chipSel_n = 1'b0;

    // Strobe style: writes, reads and boundary addresses.
    curReq = "R2"; busOp(1, 0, 8'h05, 8'hA5, 1, 0);
    curReq = "R2"; busOp(1, 0, 8'h7F, 8'h3C, 1, 0);
    curReq = "R2"; busOp(1, 0, 8'h00, 8'h81, 1, 0);
    curReq = "R1"; busOp(0, 0, 8'h05, 8'h00, 1, 0);
    curReq = "R1"; busOp(0, 0, 8'h7F, 8'h00, 1, 0);
    curReq = "R1"; busOp(0, 0, 8'h00, 8'h00, 1, 0);
    curReq = "R10"; busOp(0, 0, 8'h10, 8'h00, 1, 0);

    // Upper bus bit dropped from the address.
    curReq = "R4"; busOp(0, 0, 8'h85, 8'h00, 1, 0);

    // No chip select: address still latched, no access.
    chipSel_n = 1'b1;
    curReq = "R5"; busOp(1, 0, 8'h22, 8'hFF, 0, 0);
    curReq = "R5"; busOp(0, 0, 8'h05, 8'h00, 0, 0);
    chipSel_n = 1'b0;
    curReq = "R5"; busOp(0, 0, 8'h22, 8'h00, 1, 0);

    // Chip select lost during the pulse.
    curReq = "R6"; busOp(1, 0, 8'h05, 8'h11, 1, 1);
    curReq = "R6"; busOp(0, 0, 8'h05, 8'h00, 1, 1);
    curReq = "R6"; busOp(0, 0, 8'h05, 8'h00, 1, 0);

    // Power fail.
    powerFail = 1'b1;
    curReq = "R7"; busOp(1, 0, 8'h05, 8'h77, 0, 0);
    curReq = "R7"; busOp(0, 0, 8'h05, 8'h00, 0, 0);
    powerFail = 1'b0;
    curReq = "R7"; busOp(0, 0, 8'h05, 8'h00, 1, 0);

    // Bus reset blocks access and keeps the contents.
    busReset_n = 1'b0;
    curReq = "R8"; busOp(1, 0, 8'h7F, 8'h00, 0, 0);
    curReq = "R8"; busOp(0, 0, 8'h7F, 8'h00, 0, 0);
    busReset_n = 1'b1;
    curReq = "R8"; busOp(0, 0, 8'h7F, 8'h00, 1, 0);

    // Separate read and write pulses.
    dataStb = 1'b1; rdWr = 1'b1; modeStrap = 1'b0;
    waitCycles(3);
    curReq = "R3"; busOp(1, 0, 8'h40, 8'hC3, 1, 0);
    curReq = "R3"; busOp(0, 0, 8'h40, 8'h00, 1, 0);
    curReq = "R3"; busOp(0, 0, 8'h05, 8'h00, 1, 0);
    curReq = "R12"; busOp(0, 1, 8'h41, 8'h5A, 1, 0);
    curReq = "R12"; busOp(0, 0, 8'h41, 8'h00, 1, 0);
    chipSel_n = 1'b1;
    curReq = "R5"; busOp(1, 0, 8'h40, 8'h99, 0, 0);
    chipSel_n = 1'b0;
    curReq = "R3"; busOp(0, 0, 8'h40, 8'h00, 1, 0);

    // System reset clears the array; back to strobe style.
    dataStb = 1'b0; rdWr = 1'b1; modeStrap = 1'b1;
    rst_n = 1'b0;
    waitCycles(3);
    rst_n = 1'b1;
    oePrev = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    waitCycles(3);
    curReq = "R10"; busOp(0, 0, 8'h05, 8'h00, 1, 0);
    curReq = "R10"; busOp(0, 0, 8'h41, 8'h00, 1, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule